// File: doc/BRIEF.md
# Synchronous Serial Position Read Master

This block is the controller end of a synchronous serial link to a position sensor. A one-cycle `start` request begins a read. The block drives a clock burst of WORD_W+1 pulses on `ssi_clk`. The first falling edge tells the sensor to freeze its value. On each rising edge after that, the sensor puts one bit on `ssi_din`, most significant bit first.

The drivers and the cable delay each bit. To allow for this, the block samples `ssi_din` a programmable number of system cycles after each rising edge. The pulse width is also programmable, because the usable link rate falls as the cable gets longer. After the last pulse the block keeps the clock high for two link periods. This is the sensor's recovery time. Only then does it report the word with a one-cycle `done` pulse and accept another request.

An optional line check confirms two things: that the sensor pulled the line low after the last data bit, and that the line has gone high again by the end of the recovery time.

Top module: `ssi_rd_master`

## Requirements
- R1: After reset, `ssi_clk` is 1, and `busy`, `done`, `word` and `line_err` are all 0.
- R2: A `start` seen while `busy` is 0 is accepted, including in a `done` cycle. From the next cycle, `busy` is 1 and the burst runs. It has WORD_W+1 pulses, each `ssi_clk`=0 for H cycles and then `ssi_clk`=1 for H cycles. H is `half_cfg` as sampled at acceptance. Outside a read, `ssi_clk` stays 1.
- R3: A `start` seen while `busy` is 1 has no effect. The burst length, the `done` count and the word are unchanged, and no second read follows.
- R4: Bit k is taken from `ssi_din` D cycles after the first high cycle of the k-th rising edge. D is `dly_cfg` as sampled at acceptance. D=0 means that first high cycle itself. Any D from 0 to 2H-1 is supported.
- R5: The first bit received lands in `word[WORD_W-1]` and the last one in `word[0]`, as a plain binary value.
- R6: After the final (WORD_W+1-th) rising edge, `ssi_clk` stays 1 and `busy` stays 1 for another 4H cycles. `busy` is therefore 1 for exactly H*(2*WORD_W+5) cycles. In the following cycle, `busy` is 0 and `done` is 1.
- R7: `done` lasts one cycle. `word` changes only in a `done` cycle and holds its value until the next `done`.
- R8: `line_err` is updated in each `done` cycle and held between them. It becomes 1 in either of two cases: `ssi_din` was 1 at the sample D cycles after the final rising edge, or `ssi_din` is 0 in the last cycle of the recovery time. Otherwise it is 0.
- R9: A `half_cfg` of 0 acts as 1.
- R10: Changes to `half_cfg` or `dly_cfg` while `busy` is 1 do not affect the read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Read request, sampled each cycle |
| half_cfg | input | DIV_W | Half-period of the link clock in system cycles |
| dly_cfg | input | DLY_W | Sample delay after each rising edge, in system cycles |
| ssi_din | input | 1 | Serial data from the sensor |
| ssi_clk | output | 1 | Link clock, idles high |
| busy | output | 1 | Read or recovery time in progress |
| done | output | 1 | One-cycle pulse when a word is delivered |
| word | output | WORD_W | Last received value |
| line_err | output | 1 | Line check result of the last read |

## Verification
Two things can happen in the same cycle: the end of one read and the acceptance of the next request. The bench holds `start` high in the exact cycle where `done` is pulsing. It then expects a new burst to open in the next cycle, while `word` keeps the value just delivered. A second collision is a request, with altered settings, arriving in the middle of a burst. This one is judged by the per-cycle reference: the busy time, the clock shape and the word must all match the request that was first accepted.

// File: rtl/ssi_rd_pkg.sv
package ssi_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } ssi_state_e;
endpackage

// File: rtl/ssi_rd_clkgen.sv
module ssi_rd_clkgen #(
  parameter int WORD_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             rise,
  output logic             last_edge
);
  localparam int PC_W = $clog2(WORD_W + 2);

  logic [DIV_W-1:0] ph;
  logic [PC_W-1:0]  pc;
  logic             half_end;

  assign half_end  = (ph == half - DIV_W'(1));
  // the rising edge about to be made is the final one of the burst
  assign last_edge = run && half_end && !sclk && (pc == PC_W'(WORD_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b1;
      rise <= 1'b0;
      ph   <= '0;
      pc   <= '0;
    end else if (load) begin
      sclk <= 1'b0;
      rise <= 1'b0;
      ph   <= '0;
      pc   <= '0;
    end else if (run) begin
      if (half_end) begin
        ph   <= '0;
        sclk <= ~sclk;
        rise <= ~sclk;
        if (!sclk) pc <= pc + PC_W'(1);
      end else begin
        ph   <= ph + DIV_W'(1);
        rise <= 1'b0;
      end
    end else begin
      sclk <= 1'b1;
      rise <= 1'b0;
    end
  end
endmodule

// File: rtl/ssi_rd_sampler.sv
module ssi_rd_sampler #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             rise,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  logic [DLY_W-1:0] cnt;

  assign fire = (rise && (dly == '0)) || (!rise && (cnt == DLY_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt <= '0;
    else if (rise)         cnt <= dly;
    else if (cnt != '0)    cnt <= cnt - DLY_W'(1);
  end
endmodule

// File: rtl/ssi_rd_capture.sv
module ssi_rd_capture #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              fire,
  input  logic              din,
  output logic [WORD_W-1:0] data,
  output logic              tail_bad
);
  localparam int IDX_W = $clog2(WORD_W + 2);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx      <= '0;
      data     <= '0;
      tail_bad <= 1'b0;
    end else if (fire) begin
      if (idx < IDX_W'(WORD_W)) begin
        data <= {data[WORD_W-2:0], din};
        idx  <= idx + IDX_W'(1);
      end else if (idx == IDX_W'(WORD_W)) begin
        tail_bad <= din;
        idx      <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/ssi_rd_master.sv
module ssi_rd_master
  import ssi_rd_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 6,
  parameter bit LINE_CHK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIV_W-1:0]  half_cfg,
  input  logic [DLY_W-1:0]  dly_cfg,
  input  logic              ssi_din,
  output logic              ssi_clk,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              line_err
);
  localparam int GAP_W = DIV_W + 2;

  ssi_state_e        st;
  logic [DIV_W-1:0]  h_q;
  logic [DLY_W-1:0]  d_q;
  logic [GAP_W-1:0]  gcnt;
  logic [DIV_W-1:0]  half_eff;
  logic              accept, run, rise, last_edge, fire, tail_bad, gap_last, line_bad;
  logic [WORD_W-1:0] data;

  assign half_eff = (half_cfg == '0) ? DIV_W'(1) : half_cfg;
  assign accept   = (st == ST_IDLE) && start;
  assign run      = (st == ST_BURST);
  assign gap_last = (gcnt == ({h_q, 2'b00} - GAP_W'(1)));

  generate
    if (LINE_CHK) begin : g_line_chk
      assign line_bad = tail_bad | ~ssi_din;
    end else begin : g_no_line_chk
      assign line_bad = 1'b0;
    end
  endgenerate

  ssi_rd_clkgen #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .load(accept), .run(run), .half(h_q),
    .sclk(ssi_clk), .rise(rise), .last_edge(last_edge)
  );

  ssi_rd_sampler #(.DLY_W(DLY_W)) u_sampler (
    .clk(clk), .rst(rst), .clear(accept), .rise(rise), .dly(d_q), .fire(fire)
  );

  ssi_rd_capture #(.WORD_W(WORD_W)) u_capture (
    .clk(clk), .rst(rst), .clear(accept), .fire(fire), .din(ssi_din),
    .data(data), .tail_bad(tail_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      h_q      <= DIV_W'(1);
      d_q      <= '0;
      gcnt     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      word     <= '0;
      line_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st   <= ST_BURST;
            h_q  <= half_eff;
            d_q  <= dly_cfg;
            busy <= 1'b1;
          end
        end
        ST_BURST: begin
          if (last_edge) begin
            st   <= ST_GAP;
            gcnt <= '0;
          end
        end
        ST_GAP: begin
          if (gap_last) begin
            st       <= ST_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            word     <= data;
            line_err <= line_bad;
          end else begin
            gcnt <= gcnt + GAP_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssi_rd_master_chk.sv
module ssi_rd_master_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              ssi_clk,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] word,
  input logic              line_err
);
  // R2
  clk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ssi_clk);

  // R2
  burst_opens_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !ssi_clk));

  // R6
  busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && ssi_clk));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(word));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(line_err));
endmodule

bind ssi_rd_master ssi_rd_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ssi_clk(ssi_clk), .busy(busy),
  .done(done), .word(word), .line_err(line_err)
);

// File: tb/ssi_rd_master_bench.sv
`timescale 1ns/1ps
module ssi_rd_master_bench;
  localparam int N     = 12;
  localparam int DIV_W = 8;
  localparam int DLY_W = 6;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DIV_W-1:0] half_cfg = 8'd2;
  logic [DLY_W-1:0] dly_cfg = '0;
  logic ssi_din = 1'b1;
  logic ssi_clk, busy, done, line_err;
  logic [N-1:0] word;

  always #2.5 clk = ~clk;

  ssi_rd_master #(.WORD_W(N), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_ssi_rd_master (
    .clk(clk), .rst(rst), .start(start), .half_cfg(half_cfg), .dly_cfg(dly_cfg),
    .ssi_din(ssi_din), .ssi_clk(ssi_clk), .busy(busy), .done(done),
    .word(word), .line_err(line_err)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit wd_hit = 0, cmp_en = 0, chain_pend = 0;

  // sensor settings for the current read
  logic [N-1:0] cur_val = '0;
  int cur_pd = 0, cur_rel = 1;
  bit cur_bad = 0;

  // sensor state
  bit s_act = 0, s_prev = 1, ideal = 1;
  logic [N-1:0] s_lat = '0;
  int s_rc = 0, s_tmr = 0;
  bit hist [0:15];

  // reference model
  bit m_act = 0;
  int m_t = 0, m_h = 1, m_tot = 0;
  logic [N-1:0] m_pw = '0;
  bit m_pe = 0;
  bit e_sclk = 1, e_busy = 0, e_done = 0, e_err = 0;
  logic [N-1:0] e_word = '0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit sclk_at(input int t, input int h);
    if (t < 2*h*N + h && (t % (2*h)) < h) return 1'b0;
    return 1'b1;
  endfunction

  task automatic compare();
    n_vec++;
    if (ssi_clk !== e_sclk) begin n_bad++; $display("FAIL R2 cycle %0d ssi_clk: got %b expected %b", cyc, ssi_clk, e_sclk); end
    if (busy !== e_busy) begin n_bad++; $display("FAIL R6 cycle %0d busy: got %b expected %b", cyc, busy, e_busy); end
    if (done !== e_done) begin n_bad++; $display("FAIL R7 cycle %0d done: got %b expected %b", cyc, done, e_done); end
    if (word !== e_word) begin n_bad++; $display("FAIL R5 cycle %0d word: got %h expected %h", cyc, word, e_word); end
    if (line_err !== e_err) begin n_bad++; $display("FAIL R8 cycle %0d line_err: got %b expected %b", cyc, line_err, e_err); end
  endtask

  task automatic sensor_step();
    bit fall, rs;
    fall = s_prev && !ssi_clk;
    rs   = !s_prev && ssi_clk;
    if (!s_act && fall) begin
      s_act = 1; s_lat = cur_val; s_rc = 0; ideal = 1;
    end else if (s_act) begin
      if (rs) begin
        s_rc++;
        if (s_rc <= N) ideal = s_lat[N - s_rc];
        else begin ideal = cur_bad; s_tmr = cur_rel; end
      end else if (s_rc == N + 1) begin
        s_tmr--;
        if (s_tmr == 0) begin ideal = 1; s_act = 0; end
      end
    end
    s_prev = ssi_clk;
    for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = ideal;
    ssi_din = hist[cur_pd];
  endtask

  task automatic model_step(input bit st_now);
    bit nd;
    nd = 0;
    if (m_act) begin
      m_t++;
      if (m_t == m_tot) begin m_act = 0; nd = 1; e_word = m_pw; e_err = m_pe; end
    end else if (st_now) begin
      m_act = 1; m_t = 0;
      m_h = (half_cfg == 0) ? 1 : int'(half_cfg);
      m_tot = m_h * (2*N + 5);
      m_pw = cur_val;
      m_pe = cur_bad || (cur_rel + cur_pd > 4*m_h - 1);
    end
    e_done = nd;
    e_busy = m_act;
    e_sclk = m_act ? sclk_at(m_t, m_h) : 1'b1;
  endtask

  task automatic tick(input bit st_req);
    bit st_now;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) wd_hit = 1;
    if (cmp_en) compare();
    st_now = st_req;
    if (chain_pend && done) begin st_now = 1; chain_pend = 0; end
    start = st_now;
    sensor_step();
    model_step(st_now);
  endtask

  task automatic do_read(input logic [N-1:0] val, input int h, input int d, input int pd,
                         input int rel, input bit bad, input bit poke, input bit chain,
                         input bit started, input string tag);
    int bcnt, heff, late;
    bit got;
    cur_val = val; cur_pd = pd; cur_rel = rel; cur_bad = bad;
    half_cfg = DIV_W'(h); dly_cfg = DLY_W'(d);
    heff = (h == 0) ? 1 : h;
    if (!started) tick(1);
    bcnt = 0; got = 0;
    while (!got && !wd_hit) begin
      bit s;
      s = 0;
      if (poke && bcnt == 5) begin
        s = 1;                                   // R3 request while busy
        half_cfg = DIV_W'(h + 3); dly_cfg = '0;  // R10 settings changed mid-read
      end
      if (chain && bcnt == heff*(2*N+5) - 1) chain_pend = 1;
      tick(s);
      if (busy) bcnt++;
      if (done) got = 1;
    end
    chk("R4 R5", "word", word, val);
    chk("R8", "line_err", line_err, bad || (rel + pd > 4*heff - 1));
    chk(tag, "busy cycles", bcnt, heff*(2*N+5));
    if (!chain) begin
      late = 0;
      for (int i = 0; i < rel + pd + 3; i++) begin
        tick(0);
        if (busy || done) late++;
      end
      chk("R3", "activity after done", late, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) hist[i] = 1;
    rst = 1;
    for (int i = 0; i < 3; i++) tick(0);
    rst = 0;
    // R1 reset state
    chk("R1", "ssi_clk", ssi_clk, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "word", word, 0);
    chk("R1", "line_err", line_err, 0);
    cmp_en = 1;
    tick(0); tick(0);

    do_read(12'hA5C, 2, 1, 1, 3, 0, 0, 0, 0, "R6");
    do_read(12'hFFF, 3, 0, 0, 2, 0, 0, 0, 0, "R6");
    do_read(12'h001, 4, 7, 5, 5, 0, 0, 0, 0, "R4");   // D at 2H-1
    do_read(12'h555, 0, 1, 1, 1, 0, 0, 0, 0, "R9");   // zero half-period
    do_read(12'h3C3, 2, 1, 1, 8, 0, 0, 0, 0, "R8");   // line high too late
    do_read(12'h0F0, 2, 2, 1, 3, 1, 0, 0, 0, "R8");   // line not low after last bit
    do_read(12'hA5C, 2, 1, 1, 3, 0, 0, 0, 0, "R8");   // error clears
    do_read(12'h9E7, 3, 2, 1, 3, 0, 1, 0, 0, "R10");  // R3 and R10 poke
    do_read(12'h6A9, 2, 1, 1, 3, 0, 0, 1, 0, "R2");   // start in done cycle
    do_read(12'h6A9, 2, 1, 1, 3, 0, 0, 0, 1, "R2");

    if (wd_hit) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WD_LIMIT);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule